// File: doc/BRIEF.md
# Receive Channel Power-Down and Bypass Gate

This block sits at the end of a two-lane receive sample path and decides, per lane, what reaches the output: the processed sample, the raw unprocessed sample, or a fixed mid-scale code. The decision comes from an 8-bit control register loaded through a plain write port. The register holds four kinds of bit:

- a master off bit that silences both lanes;
- a power-down request for each lane, each with its own arming bit;
- a raw-path select, also with its own arming bit.

A request bit does nothing unless its arming bit is also set.

A side input, `feat_on`, tells the block whether any optional digital processing feature is active upstream. While it is low, the lanes can only be powered down together, and only with all four lane bits set. While it is high, each lane obeys its own request and arming pair. Each lane also drives a level `pwr_en_*` that is high while the lane is live.

Samples move through a single output register with valid/ready handshakes on both sides. An input beat is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle (`!out_valid || out_ready`). A held output beat keeps its value and stays valid until `out_ready` is seen high. The gating decision uses the control register value in force at the accepting clock edge.

Top module: `rxg_gate`

## Requirements
- R1: After reset the control register is 0x00. Both `pwr_en_a` and `pwr_en_b` are 1, and accepted beats carry the processed samples.
- R2: When `cfg_we` is high at a clock edge, the register takes `cfg_wdata` at that edge. `pwr_en_*` reflect the new value from that edge on, and beats accepted at later edges use it.
- R3: Bit 0 (master off) set forces both lanes off: both `pwr_en` signals are 0 and both outputs are the mid-scale code 2^(DATA_W-1), which is 0x800 for 12 bits.
- R4: A lane power-down request (bit 1 for lane A, bit 3 for lane B) has no effect unless its arming bit (bit 2 for A, bit 4 for B) is also 1.
- R5: With `feat_on`=0, a lane powers down only when bits 1, 2, 3 and 4 are all 1, and then both lanes are off. `pwr_en_a` always equals `pwr_en_b`.
- R6: With `feat_on`=1, lane A is off exactly when bits 1 and 2 are set, and lane B is off exactly when bits 3 and 4 are set, each lane independently of the other.
- R7: With bit 5 (raw select) and bit 6 (its arming bit) both 1, a live lane outputs its raw input instead of the processed one. Either bit alone has no effect.
- R8: A lane that is off outputs mid-scale even when the raw select is armed.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output beat stays unchanged and valid. `in_ready` equals `!out_valid || out_ready`.
- R10: Bit 7 of the register has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write value |
| feat_on | input | 1 | High when any optional digital feature is enabled |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| proc_a | input | DATA_W | Processed sample, lane A |
| proc_b | input | DATA_W | Processed sample, lane B |
| raw_a | input | DATA_W | Raw sample, lane A |
| raw_b | input | DATA_W | Raw sample, lane B |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts output beat |
| out_a | output | DATA_W | Output sample, lane A |
| out_b | output | DATA_W | Output sample, lane B |
| pwr_en_a | output | 1 | Lane A live |
| pwr_en_b | output | 1 | Lane B live |

## Verification
The bench builds the block with the default DATA_W of 12. That places mid-scale at 0x800, which random 12-bit samples hit only rarely, so a wrong or stale mid-scale value shows up clearly. Random register values are drawn over all 256 codes while `feat_on` toggles, which reaches every qualified and unqualified combination of the lane and raw-select bits in both modes. Random `out_ready` stalls exercise holding and back-pressure alongside register writes that land while a beat is held.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  localparam int CFG_W = 8;

  // Field order is the register bit order, MSB first.
  typedef struct packed {
    logic spare;    // bit 7
    logic raw_arm;  // bit 6
    logic raw_sel;  // bit 5
    logic b_arm;    // bit 4
    logic b_down;   // bit 3
    logic a_arm;    // bit 2
    logic a_down;   // bit 1
    logic all_off;  // bit 0
  } rxg_cfg_t;
endpackage

// File: rtl/rxg_cfg_reg.sv
module rxg_cfg_reg
  import rxg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             feat_on,
  output logic             off_a,
  output logic             off_b,
  output logic             raw_act
);
  rxg_cfg_t cfg_q;
  logic req_a, req_b, pd_a, pd_b;
  logic unused_spare;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= '0;
    else if (we) cfg_q <= rxg_cfg_t'(wdata);
  end

  always_comb begin
    req_a = cfg_q.a_down & cfg_q.a_arm;
    req_b = cfg_q.b_down & cfg_q.b_arm;
    if (feat_on) begin
      pd_a = req_a;
      pd_b = req_b;
    end else begin
      pd_a = req_a & req_b;
      pd_b = req_a & req_b;
    end
    off_a   = cfg_q.all_off | pd_a;
    off_b   = cfg_q.all_off | pd_b;
    raw_act = cfg_q.raw_sel & cfg_q.raw_arm;
  end

  assign unused_spare = cfg_q.spare;

  a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[0]) |=> (off_a && off_b));
endmodule

// File: rtl/rxg_lane_sel.sv
module rxg_lane_sel #(
  parameter int DATA_W = 12
) (
  input  logic              off,
  input  logic              raw_act,
  input  logic [DATA_W-1:0] proc_s,
  input  logic [DATA_W-1:0] raw_s,
  output logic [DATA_W-1:0] sel_s
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  always_comb begin
    if (off)          sel_s = MID;
    else if (raw_act) sel_s = raw_s;
    else              sel_s = proc_s;
  end
endmodule

// File: rtl/rxg_out_stage.sv
module rxg_out_stage #(
  parameter int WIDTH = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/rxg_gate.sv
module rxg_gate
  import rxg_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              feat_on,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] proc_a,
  input  logic [DATA_W-1:0] proc_b,
  input  logic [DATA_W-1:0] raw_a,
  input  logic [DATA_W-1:0] raw_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              pwr_en_a,
  output logic              pwr_en_b
);
  localparam int LANES = 2;
  localparam int BUS_W = LANES * DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic off_a, off_b, raw_act;
  logic [LANES-1:0]             lane_off;
  logic [LANES-1:0][DATA_W-1:0] lane_proc, lane_raw, lane_sel;
  logic [BUS_W-1:0]             bus_q;

  rxg_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .feat_on(feat_on), .off_a(off_a), .off_b(off_b), .raw_act(raw_act)
  );

  assign lane_off  = {off_b, off_a};
  assign lane_proc = {proc_b, proc_a};
  assign lane_raw  = {raw_b, raw_a};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rxg_lane_sel #(.DATA_W(DATA_W)) u_sel (
      .off(lane_off[g]), .raw_act(raw_act),
      .proc_s(lane_proc[g]), .raw_s(lane_raw[g]), .sel_s(lane_sel[g])
    );
  end

  rxg_out_stage #(.WIDTH(BUS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(lane_sel), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(bus_q)
  );

  assign out_a    = bus_q[DATA_W-1:0];
  assign out_b    = bus_q[BUS_W-1:DATA_W];
  assign pwr_en_a = !off_a;
  assign pwr_en_b = !off_b;

  a_r9_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  a_r5_together: assert property (@(posedge clk) disable iff (!rst_n)
    !feat_on |-> (pwr_en_a == pwr_en_b));

  a_r8_off_mid_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pwr_en_a) |=> (out_a == MID));

  a_r8_off_mid_b: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !pwr_en_b) |=> (out_b == MID));

  a_r7_raw_a: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && pwr_en_a && raw_act) |=> (out_a == $past(raw_a)));
endmodule

// File: tb/rxg_gate_tb.sv
module rxg_gate_tb;
  localparam int CLK_NS = 10;
  localparam int W = 12;
  localparam logic [W-1:0] MID = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, feat_on = 1'b0, in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [W-1:0] proc_a = '0, proc_b = '0, raw_a = '0, raw_b = '0;
  logic in_ready, out_valid, pwr_en_a, pwr_en_b;
  logic [W-1:0] out_a, out_b;

  int n_chk = 0, n_bad = 0;
  logic [7:0] cfg_m = '0;
  logic ev = 1'b0;
  logic [W-1:0] ea = '0, eb = '0;
  string etag = "R1";

  always #(CLK_NS/2) clk = ~clk;

  rxg_gate #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .feat_on(feat_on), .in_valid(in_valid), .in_ready(in_ready),
    .proc_a(proc_a), .proc_b(proc_b), .raw_a(raw_a), .raw_b(raw_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_a(out_a), .out_b(out_b),
    .pwr_en_a(pwr_en_a), .pwr_en_b(pwr_en_b)
  );

  function automatic logic m_off(input logic [7:0] c, input logic f, input bit lane_b);
    logic ra, rb;
    ra = c[1] & c[2];
    rb = c[3] & c[4];
    if (c[0]) return 1'b1;
    if (!f)   return ra & rb;
    return lane_b ? rb : ra;
  endfunction

  function automatic logic [W-1:0] m_out(input logic [7:0] c, input logic f, input bit lane_b,
                                         input logic [W-1:0] p, input logic [W-1:0] r);
    if (m_off(c, f, lane_b)) return MID;
    if (c[5] & c[6]) return r;
    return p;
  endfunction

  function automatic string m_tag(input logic [7:0] c, input logic f);
    if (c[0]) return "R3";
    if ((c[5] & c[6]) && (m_off(c, f, 0) || m_off(c, f, 1))) return "R8";
    if (!f && (c[1] | c[3])) return "R5";
    if (f && ((c[1] & c[2]) || (c[3] & c[4]))) return "R6";
    if (c[1] | c[3]) return "R4";
    if (c[5] | c[6]) return "R7";
    if (c[7]) return "R10";
    return "R1";
  endfunction

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Called at a negedge: compare, then apply the next stimulus and advance the model.
  task automatic cyc(input logic v, input logic rdy, input logic we, input logic [7:0] wd, input logic f);
    chk("R9", "out_valid", W'(out_valid), W'(ev));
    chk("R9", "in_ready", W'(in_ready), W'(!ev || out_ready));
    chk("R2", "pwr_en_a", W'(pwr_en_a), W'(!m_off(cfg_m, feat_on, 0)));
    chk("R2", "pwr_en_b", W'(pwr_en_b), W'(!m_off(cfg_m, feat_on, 1)));
    if (ev) begin
      chk(etag, "out_a", out_a, ea);
      chk(etag, "out_b", out_b, eb);
    end
    in_valid = v; out_ready = rdy; cfg_we = we; cfg_wdata = wd; feat_on = f;
    proc_a = W'($urandom); proc_b = W'($urandom);
    raw_a = W'($urandom);  raw_b = W'($urandom);
    if (v && (!ev || rdy)) begin
      ev = 1'b1;
      ea = m_out(cfg_m, f, 0, proc_a, raw_a);
      eb = m_out(cfg_m, f, 1, proc_b, raw_b);
      etag = m_tag(cfg_m, f);
    end else if (rdy) begin
      ev = 1'b0;
    end
    if (we) cfg_m = wd;
    @(negedge clk);
  endtask

  task automatic dir(input logic [7:0] c, input logic f);
    cyc(1'b0, 1'b1, 1'b1, c, f);
    cyc(1'b1, 1'b1, 1'b0, 8'h00, f);
    cyc(1'b1, 1'b1, 1'b0, 8'h00, f);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "reset pwr_en_a", W'(pwr_en_a), W'(1));
    chk("R1", "reset pwr_en_b", W'(pwr_en_b), W'(1));
    chk("R1", "reset out_valid", W'(out_valid), W'(0));
    cyc(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
    // Directed corners
    dir(8'h01, 1'b1);  // R3 master off
    dir(8'h02, 1'b1);  // R4 lane A request without arming
    dir(8'h18, 1'b0);  // R4 lane B request with arming, default mode alone
    dir(8'h06, 1'b0);  // R5 lane A only, default mode: no effect
    dir(8'h1E, 1'b0);  // R5 all four bits
    dir(8'h06, 1'b1);  // R6 lane A only
    dir(8'h18, 1'b1);  // R6 lane B only
    dir(8'h60, 1'b0);  // R7 raw select armed
    dir(8'h20, 1'b0);  // R7 select without arming
    dir(8'h66, 1'b1);  // R8 A off, B raw
    dir(8'h61, 1'b0);  // R8 master off beats raw
    dir(8'h80, 1'b0);  // R10 spare bit
    // R9 stall: fill, hold several cycles, then drain
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    cyc(1'b1, 1'b0, 1'b1, 8'h01, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 5) == 0,
          8'($urandom), ($urandom % 2) == 1);
    end
    cyc(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule